// File: doc/BRIEF.md
# Processor Exception Dispatch Unit

This block keeps the exception-related state of a processor core and updates it when the core raises a general exception or a debug exception. In one clock edge it records the faulting PC, the cause code and an optional faulting virtual address. It updates the processor status word and reports which exception vector the fetch logic should jump to. The vector index is reported as a single-cycle valid pulse.

The status word has three fields: an interrupt level, an exception-mode flag and a user-mode flag. A general exception taken while exception mode is already set is a nested fault. Its PC goes to a separate double-exception PC register, and it selects the double-exception vector. Otherwise the PC goes to the first-level exception PC register, and the user-mode flag chooses between the user vector and the kernel vector.

A debug exception is accepted only when the current interrupt level is below the configured debug level. When accepted, it saves the PC and the old status word into a level-indexed bank, raises the interrupt level to the debug level and selects the debug vector. The core can overwrite the status word through a write port. The level bank can be read back through a registered read port.

Top module: `exc_dispatch`

## Requirements
- R1: For a taken general exception, the PC is written to `epc1` when the exception-mode flag was clear. When the flag was already set (double-exception storage is enabled by default), the PC is written to `depc` instead. The other of the two registers keeps its value.
- R2: The vector index is 2 (double) if the exception-mode flag was set before the exception. Otherwise it is 1 (user) when the user flag was set and 0 (kernel) when it was clear. `vec_valid` is high for exactly the one cycle after the edge that took the request.
- R3: Every taken general exception writes `exc_cause` into `cause_q` and sets the exception-mode flag (status bit 4). The user flag (bit 5) and the interrupt level (bits 3:0) are left unchanged.
- R4: A general exception taken with `exc_addr_vld` high writes `exc_addr` into `vaddr_q`. Without `exc_addr_vld`, `vaddr_q` keeps its value.
- R5: A taken debug exception writes `dbg_cause` into `dbg_cause_q`. It stores the PC and the previous status word in bank entry DBG_LEVEL. That entry is read through `lvl_sel`, with `lvl_pc`/`lvl_ps` valid one cycle after the entry is written. `epc1`, `depc` and `cause_q` are untouched.
- R6: A taken debug exception sets the interrupt level to DBG_LEVEL (default 6), sets the exception-mode flag, keeps the user flag, and outputs vector index 3.
- R7: A debug request is ignored when the interrupt level is greater than or equal to DBG_LEVEL. It then changes no state and produces no `vec_valid`.
- R8: When debug and general requests arrive in the same cycle and the debug request is eligible, only the debug exception is taken. When the debug request is not eligible, the general exception is taken.
- R9: `ps_wr_en` loads `ps_wr_data` into the status word in a cycle where no exception is taken. In a cycle where an exception is taken, the write is ignored.
- R10: Synchronous active-high reset clears every register and the level bank. The exception exception: the status word resets to 0x10, that is, with the exception-mode flag set, the user flag clear and interrupt level 0. `vec_valid` resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | General exception request |
| exc_pc | input | XLEN | PC of the faulting instruction |
| exc_cause | input | CAUSE_W | General exception cause code |
| exc_addr_vld | input | 1 | Request carries a faulting virtual address |
| exc_addr | input | XLEN | Faulting virtual address |
| dbg_req | input | 1 | Debug exception request (uses `exc_pc`) |
| dbg_cause | input | CAUSE_W | Debug cause code |
| ps_wr_en | input | 1 | Status word write strobe from the core |
| ps_wr_data | input | ILVL_W+2 | New status word {user, excmode, level} |
| lvl_sel | input | ILVL_W | Level bank read index |
| status | output | ILVL_W+2 | Current status word |
| epc1 | output | XLEN | First-level exception PC |
| depc | output | XLEN | Double-exception PC |
| cause_q | output | CAUSE_W | Exception cause register |
| vaddr_q | output | XLEN | Exception virtual address register |
| dbg_cause_q | output | CAUSE_W | Debug cause register |
| lvl_pc | output | XLEN | Saved PC of the selected level (registered) |
| lvl_ps | output | ILVL_W+2 | Saved status of the selected level (registered) |
| vec_valid | output | 1 | One-cycle vector pulse |
| vec_idx | output | 2 | Vector index: 0 kernel, 1 user, 2 double, 3 debug |

## Verification
General exceptions are raised from three starting states: kernel, user and already in exception mode. Each of the three vectors and PC destinations must then appear on its own. Requests with and without a faulting address show that the address register changes only when asked. Debug requests are tried at interrupt levels below, equal to and above the debug level, which places the eligibility boundary exactly. Combined debug and general requests at eligible and ineligible levels tell the priority apart from plain precedence. A status write in the same cycle as an exception shows whether it is dropped.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int VEC_W = 2;

  typedef enum logic [VEC_W-1:0] {
    VEC_KERNEL = 2'd0,
    VEC_USER   = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;

endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
  import exc_pkg::*;
#(
  parameter int ILVL_W    = 4,
  parameter int DBG_LEVEL = 6
) (
  input  logic              exc_req,
  input  logic              dbg_req,
  input  logic              excm,
  input  logic              um,
  input  logic [ILVL_W-1:0] intlevel,
  output logic              take_dbg,
  output logic              take_gen,
  output logic              nested,
  output vec_e              vec
);

  localparam logic [ILVL_W-1:0] DBG_LVL_V = ILVL_W'(DBG_LEVEL);

  logic dbg_ok;

  always_comb begin
    dbg_ok   = dbg_req && (intlevel < DBG_LVL_V);
    take_dbg = dbg_ok;
    take_gen = exc_req && !dbg_ok;
    nested   = take_gen && excm;
    if (dbg_ok)       vec = VEC_DEBUG;
    else if (excm)    vec = VEC_DOUBLE;
    else if (um)      vec = VEC_USER;
    else              vec = VEC_KERNEL;
  end

endmodule

// File: rtl/exc_level_bank.sv
module exc_level_bank #(
  parameter int XLEN    = 32,
  parameter int PS_W    = 6,
  parameter int LVL_W   = 4,
  parameter int NUM_LVL = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] wr_lvl,
  input  logic [XLEN-1:0]  wr_pc,
  input  logic [PS_W-1:0]  wr_ps,
  input  logic [LVL_W-1:0] rd_lvl,
  output logic [XLEN-1:0]  rd_pc,
  output logic [PS_W-1:0]  rd_ps
);

  localparam int DEPTH = NUM_LVL + 1;

  logic [XLEN-1:0] pc_mem [DEPTH];
  logic [PS_W-1:0] ps_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        pc_mem[i] <= '0;
        ps_mem[i] <= '0;
      end
    end else if (wr_en && (int'(wr_lvl) < DEPTH)) begin
      pc_mem[wr_lvl] <= wr_pc;
      ps_mem[wr_lvl] <= wr_ps;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pc <= '0;
      rd_ps <= '0;
    end else if (int'(rd_lvl) < DEPTH) begin
      rd_pc <= pc_mem[rd_lvl];
      rd_ps <= ps_mem[rd_lvl];
    end else begin
      rd_pc <= '0;
      rd_ps <= '0;
    end
  end

  AST_BANK_WR_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(wr_lvl) < DEPTH)) else $error("bank write out of range"); // R5

endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
  import exc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 6,
  parameter int ILVL_W    = 4,
  parameter int NUM_LVL   = 7,
  parameter int DBG_LEVEL = 6,
  parameter bit HAS_DEPC  = 1'b1,
  localparam int PS_W     = ILVL_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               exc_req,
  input  logic [XLEN-1:0]    exc_pc,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               exc_addr_vld,
  input  logic [XLEN-1:0]    exc_addr,
  input  logic               dbg_req,
  input  logic [CAUSE_W-1:0] dbg_cause,
  input  logic               ps_wr_en,
  input  logic [PS_W-1:0]    ps_wr_data,
  input  logic [ILVL_W-1:0]  lvl_sel,
  output logic [PS_W-1:0]    status,
  output logic [XLEN-1:0]    epc1,
  output logic [XLEN-1:0]    depc,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [XLEN-1:0]    vaddr_q,
  output logic [CAUSE_W-1:0] dbg_cause_q,
  output logic [XLEN-1:0]    lvl_pc,
  output logic [PS_W-1:0]    lvl_ps,
  output logic               vec_valid,
  output logic [1:0]         vec_idx
);

  localparam int EXCM_BIT = ILVL_W;
  localparam int UM_BIT   = ILVL_W + 1;
  localparam logic [ILVL_W-1:0] DBG_LVL_V = ILVL_W'(DBG_LEVEL);
  localparam logic [PS_W-1:0]   PS_RESET  = PS_W'(1) << EXCM_BIT;

  logic [PS_W-1:0]    ps_q;
  logic [XLEN-1:0]    epc1_q, depc_q, vaddr_r;
  logic [CAUSE_W-1:0] cause_r, dbgc_r;
  logic               vv_q;
  vec_e               vec_q;

  logic take_dbg, take_gen, nested;
  vec_e vec_n;

  exc_vec_sel #(
    .ILVL_W    (ILVL_W),
    .DBG_LEVEL (DBG_LEVEL)
  ) u_sel (
    .exc_req  (exc_req),
    .dbg_req  (dbg_req),
    .excm     (ps_q[EXCM_BIT]),
    .um       (ps_q[UM_BIT]),
    .intlevel (ps_q[ILVL_W-1:0]),
    .take_dbg (take_dbg),
    .take_gen (take_gen),
    .nested   (nested),
    .vec      (vec_n)
  );

  exc_level_bank #(
    .XLEN    (XLEN),
    .PS_W    (PS_W),
    .LVL_W   (ILVL_W),
    .NUM_LVL (NUM_LVL)
  ) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (take_dbg),
    .wr_lvl (DBG_LVL_V),
    .wr_pc  (exc_pc),
    .wr_ps  (ps_q),
    .rd_lvl (lvl_sel),
    .rd_pc  (lvl_pc),
    .rd_ps  (lvl_ps)
  );

  // status word
  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q <= PS_RESET;
    end else if (take_dbg) begin
      ps_q[ILVL_W-1:0] <= DBG_LVL_V;
      ps_q[EXCM_BIT]   <= 1'b1;
    end else if (take_gen) begin
      ps_q[EXCM_BIT]   <= 1'b1;
    end else if (ps_wr_en) begin
      ps_q <= ps_wr_data;
    end
  end

  // exception PC registers
  generate
    if (HAS_DEPC) begin : g_depc
      always_ff @(posedge clk) begin
        if (rst) begin
          epc1_q <= '0;
          depc_q <= '0;
        end else if (take_gen) begin
          if (nested) depc_q <= exc_pc;
          else        epc1_q <= exc_pc;
        end
      end
    end else begin : g_no_depc
      always_ff @(posedge clk) begin
        if (rst) begin
          epc1_q <= '0;
        end else if (take_gen) begin
          epc1_q <= exc_pc;
        end
      end
      assign depc_q = '0;
    end
  endgenerate

  // cause, address and debug cause
  always_ff @(posedge clk) begin
    if (rst) begin
      cause_r <= '0;
      vaddr_r <= '0;
      dbgc_r  <= '0;
    end else begin
      if (take_gen) cause_r <= exc_cause;
      if (take_gen && exc_addr_vld) vaddr_r <= exc_addr;
      if (take_dbg) dbgc_r <= dbg_cause;
    end
  end

  // vector pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      vv_q  <= 1'b0;
      vec_q <= VEC_KERNEL;
    end else begin
      vv_q  <= take_dbg || take_gen;
      vec_q <= vec_n;
    end
  end

  assign status      = ps_q;
  assign epc1        = epc1_q;
  assign depc        = depc_q;
  assign cause_q     = cause_r;
  assign vaddr_q     = vaddr_r;
  assign dbg_cause_q = dbgc_r;
  assign vec_valid   = vv_q;
  assign vec_idx     = vec_q;

  AST_NESTED_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (take_gen && ps_q[EXCM_BIT]) |=> (vec_valid && vec_idx == 2'd2)) else $error("nested vector"); // R2

  AST_FIRST_KEEPS_DEPC: assert property (@(posedge clk) disable iff (rst)
    (take_gen && !ps_q[EXCM_BIT]) |=> $stable(depc)) else $error("depc touched"); // R1

  AST_EXCM_AFTER_GEN: assert property (@(posedge clk) disable iff (rst)
    take_gen |=> (status[EXCM_BIT] && cause_q == $past(exc_cause))) else $error("excm/cause"); // R3

  AST_DBG_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (dbg_req && !exc_req && ps_q[ILVL_W-1:0] >= DBG_LVL_V) |=> !vec_valid) else $error("debug not blocked"); // R7

  AST_DBG_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && vec_idx == 2'd3) |-> (status[ILVL_W-1:0] == DBG_LVL_V && status[EXCM_BIT])) else $error("debug level"); // R6

  AST_DBG_WINS: assert property (@(posedge clk) disable iff (rst)
    (dbg_req && exc_req && ps_q[ILVL_W-1:0] < DBG_LVL_V) |=> ($stable(cause_q) && vec_idx == 2'd3)) else $error("priority"); // R8

endmodule

// File: tb/exc_dispatch_tb.sv
module exc_dispatch_tb;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int CW   = 6;
  localparam int PSW  = 6;
  localparam int DBGL = 6;
  localparam int NV   = 10;
  // entry: kind[78:77] (0 gen, 1 gen+addr, 2 dbg, 3 both), pre_en[76], pre_ps[75:70], pc[69:38], cause[37:32], addr[31:0]
  localparam logic [78:0] TBL [NV] = '{
    {2'd0, 1'b0, 6'h00, 32'h0000_1000, 6'd3,  32'h0},
    {2'd0, 1'b1, 6'h00, 32'h0000_2004, 6'd5,  32'h0},
    {2'd1, 1'b1, 6'h20, 32'h0000_3008, 6'd9,  32'hDEAD_B000},
    {2'd2, 1'b1, 6'h03, 32'h0000_400C, 6'd1,  32'h0},
    {2'd2, 1'b0, 6'h00, 32'h0000_5010, 6'd2,  32'h0},
    {2'd0, 1'b0, 6'h00, 32'h0000_6014, 6'd7,  32'h1234_5678},
    {2'd3, 1'b1, 6'h25, 32'h0000_7018, 6'd4,  32'h0},
    {2'd3, 1'b1, 6'h27, 32'h0000_801C, 6'd11, 32'h0},
    {2'd2, 1'b1, 6'h06, 32'h0000_9020, 6'd12, 32'h0},
    {2'd2, 1'b1, 6'h05, 32'h0000_A024, 6'd13, 32'h0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic exc_req = 0, exc_addr_vld = 0, dbg_req = 0, ps_wr_en = 0;
  logic [XLEN-1:0] exc_pc = '0, exc_addr = '0;
  logic [CW-1:0] exc_cause = '0, dbg_cause = '0;
  logic [PSW-1:0] ps_wr_data = '0;
  logic [3:0] lvl_sel = 4'(DBGL);
  logic [PSW-1:0] status, lvl_ps;
  logic [XLEN-1:0] epc1, depc, vaddr_q, lvl_pc;
  logic [CW-1:0] cause_q, dbg_cause_q;
  logic vec_valid;
  logic [1:0] vec_idx;

  int checks = 0, errors = 0;

  logic [PSW-1:0] m_ps;
  logic [XLEN-1:0] m_epc1, m_depc, m_vaddr, m_lpc;
  logic [CW-1:0] m_cause, m_dbgc;
  logic [PSW-1:0] m_lps;
  logic m_vv;
  logic [1:0] m_vec;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_dispatch u_dut (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_pc(exc_pc), .exc_cause(exc_cause),
    .exc_addr_vld(exc_addr_vld), .exc_addr(exc_addr), .dbg_req(dbg_req), .dbg_cause(dbg_cause),
    .ps_wr_en(ps_wr_en), .ps_wr_data(ps_wr_data), .lvl_sel(lvl_sel), .status(status),
    .epc1(epc1), .depc(depc), .cause_q(cause_q), .vaddr_q(vaddr_q), .dbg_cause_q(dbg_cause_q),
    .lvl_pc(lvl_pc), .lvl_ps(lvl_ps), .vec_valid(vec_valid), .vec_idx(vec_idx)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ps = 6'h10; m_epc1 = '0; m_depc = '0; m_vaddr = '0; m_cause = '0;
    m_dbgc = '0; m_lpc = '0; m_lps = '0; m_vv = 0; m_vec = 0;
  endtask

  task automatic check_state(input string tag);
    chk({tag, " R3/R6/R9 status"}, 32'(status), 32'(m_ps));
    chk({tag, " R1 epc1"}, epc1, m_epc1);
    chk({tag, " R1 depc"}, depc, m_depc);
    chk({tag, " R3 cause"}, 32'(cause_q), 32'(m_cause));
    chk({tag, " R4 vaddr"}, vaddr_q, m_vaddr);
    chk({tag, " R5 dbg cause"}, 32'(dbg_cause_q), 32'(m_dbgc));
    chk({tag, " R5 level pc"}, lvl_pc, m_lpc);
    chk({tag, " R5 level ps"}, 32'(lvl_ps), 32'(m_lps));
  endtask

  // drive one request at negedge, check vector at next negedge, state one cycle later
  task automatic do_req(input logic [1:0] kind, input logic [31:0] pc, input logic [5:0] cause,
                        input logic [31:0] addr, input logic wr_en, input logic [5:0] wr_ps,
                        input string tag);
    logic dok, gen;
    exc_req = (kind != 2'd2); dbg_req = kind[1]; exc_addr_vld = (kind == 2'd1);
    exc_pc = pc; exc_cause = cause; dbg_cause = cause; exc_addr = addr;
    ps_wr_en = wr_en; ps_wr_data = wr_ps;
    dok = kind[1] && (m_ps[3:0] < 4'(DBGL));
    gen = (kind != 2'd2) && !dok;
    m_vv = dok || gen;
    if (dok) begin
      m_dbgc = cause; m_lpc = pc; m_lps = m_ps;
      m_ps = {m_ps[5], 1'b1, 4'(DBGL)}; m_vec = 2'd3;
    end else if (gen) begin
      if (m_ps[4]) begin m_depc = pc; m_vec = 2'd2; end
      else begin m_epc1 = pc; m_vec = m_ps[5] ? 2'd1 : 2'd0; end
      m_cause = cause;
      if (kind == 2'd1) m_vaddr = addr;
      m_ps[4] = 1'b1;
    end else if (wr_en) begin
      m_ps = wr_ps;
    end
    @(negedge clk);
    exc_req = 0; dbg_req = 0; exc_addr_vld = 0; ps_wr_en = 0;
    chk({tag, " R2/R7 vec_valid"}, 32'(vec_valid), 32'(m_vv));
    if (m_vv) chk({tag, " R2/R6/R8 vec_idx"}, 32'(vec_idx), 32'(m_vec));
    @(negedge clk);
    chk({tag, " R2 pulse ends"}, 32'(vec_valid), 32'd0);
    check_state(tag);
  endtask

  task automatic write_ps(input logic [5:0] v);
    ps_wr_en = 1; ps_wr_data = v;
    @(negedge clk);
    ps_wr_en = 0;
    m_ps = v;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 reset vec_valid", 32'(vec_valid), 32'd0);
    check_state("R10 reset");

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][76]) write_ps(TBL[i][75:70]);
      do_req(TBL[i][78:77], TBL[i][69:38], TBL[i][37:32], TBL[i][31:0], 1'b0, 6'h0,
             $sformatf("vec%0d", i));
    end

    // R9: plain status write
    write_ps(6'h21);
    @(negedge clk);
    chk("R9 status write", 32'(status), 32'h21);
    // R9: write dropped when general exception taken
    do_req(2'd0, 32'h0000_B000, 6'd20, 32'h0, 1'b1, 6'h0F, "R9 drop");
    // R9: write dropped when debug taken
    write_ps(6'h01);
    do_req(2'd2, 32'h0000_C000, 6'd21, 32'h0, 1'b1, 6'h2F, "R9 dropdbg");
    // R7: debug above level with no general: nothing
    write_ps(6'h08);
    do_req(2'd2, 32'h0000_D000, 6'd22, 32'h0, 1'b0, 6'h0, "R7 above");
    // R5: reading an unwritten level returns reset value
    lvl_sel = 4'd3;
    @(negedge clk); @(negedge clk);
    chk("R5 other level pc", lvl_pc, 32'h0);
    lvl_sel = 4'(DBGL);

    // R10: reset mid-run
    rst = 1;
    @(negedge clk);
    rst = 0;
    model_reset();
    @(negedge clk);
    chk("R10 re-reset vec_valid", 32'(vec_valid), 32'd0);
    check_state("R10 re-reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule